// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Read Latency

This block is a true dual-ported static memory. Its two ports, A and B, are fully independent: each has its own clock, reset, address, write data, read data, write strobe, a pair of chip selects of opposite polarity, a live output-drive control and a latency select. Every address, data and control input is captured in a register on the rising edge of its port's clock. The memory operation is then decoded from those captured values.

Each port picks its read latency at run time. In flow-through mode the addressed word appears in the cycle right after the capturing edge. In pipelined mode it appears one cycle later. The off-chip tri-state driver is modelled as a drive-enable output, `x_rvalid`, placed beside the data. This keeps the block synthesizable. `x_rvalid` also serves as the valid of the read stream. A RAM cannot stall, so the stream has no ready and no back-pressure: a consumer must take each word in the cycle `x_rvalid` is high. `x_rdata` is zero whenever `x_rvalid` is low.

Both ports may use the same word in the same cycle, and there is no arbitration. The same-cycle rules assume the two ports are clocked from the same edge:
- When both ports write one word in the same cycle, port B's data is kept.
- A read of a word that the other port writes in that cycle returns the previous contents.

Top module: `dpr_sync_ram`

## Requirements
- R1: A port is selected only when its captured `x_sel_n` is 0 and its captured `x_sel` is 1. With any other pair, a write has no effect on memory and `x_rvalid` stays 0 in flow-through mode.
- R2: A selected port with `x_wr_n` = 0 at an edge stores the captured `x_wdata` at the captured `x_addr`. A read of that word captured at any later edge returns the new data. In flow-through mode `x_rvalid` is 0 in the cycle after a write is captured.
- R3: In flow-through mode (`x_pipe` = 0), a selected read (`x_wr_n` = 1) captured at edge k drives the stored word on `x_rdata` with `x_rvalid` = 1 between edge k and edge k+1, provided `x_drive_n` is 0.
- R4: `x_drive_n` = 1 forces `x_rvalid` to 0 at once, with no clock edge. Returning it to 0 restores the pending read output within the same cycle.
- R5: In pipelined mode (`x_pipe` = 1), the read captured at edge k is presented between edge k+1 and edge k+2, one cycle later than in flow-through mode.
- R6: The latency select of one port has no effect on the other, so one port can run flow-through while the other runs pipelined.
- R7: When both ports write the same word in the same cycle, the word afterwards holds port B's data.
- R8: A read on one port of a word that the other port writes in the same cycle returns the word's previous contents.
- R9: While `x_rst_n` is 0, `x_rvalid` is 0 and no write reaches memory, whatever the other inputs are.
- R10: Both ports may read the same word in the same cycle, and each receives its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A active-low synchronous reset |
| a_sel_n | input | 1 | Port A active-low chip select |
| a_sel | input | 1 | Port A active-high chip select |
| a_wr_n | input | 1 | Port A write strobe, 0 = write, 1 = read |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_pipe | input | 1 | Port A latency select, 1 = pipelined |
| a_drive_n | input | 1 | Port A asynchronous active-low output drive |
| a_rdata | output | DW | Port A read data |
| a_rvalid | output | 1 | Port A read valid / drive enable |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B active-low synchronous reset |
| b_sel_n | input | 1 | Port B active-low chip select |
| b_sel | input | 1 | Port B active-high chip select |
| b_wr_n | input | 1 | Port B write strobe, 0 = write, 1 = read |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_pipe | input | 1 | Port B latency select, 1 = pipelined |
| b_drive_n | input | 1 | Port B asynchronous active-low output drive |
| b_rdata | output | DW | Port B read data |
| b_rvalid | output | 1 | Port B read valid / drive enable |

## Verification
Each bank pair holds a word only as the XOR of two entries. A lost or misdirected write therefore surfaces as a corrupt value on the first later read of that word, on either port, in the cycle after that read is captured (or one cycle later in pipelined mode).

A wrong captured select or mode shows up in the very next cycle, as `x_rvalid` high where none was expected or as data arriving one cycle early or late. A broken collision rule shows only on a later read of the contested word. The bench therefore reads every contested word back from both ports right after the collision.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  // Decoded operation of one port, built from its captured inputs.
  typedef struct packed {
    logic rd;    // selected read
    logic wr;    // selected write
    logic pipe;  // two-cycle read latency
  } dpr_op_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          pipe,
  output dpr_op_t       op,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  logic sel_n_q, sel_q, wr_n_q, pipe_q;

  // Every control, address and data input is registered on the port clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_n_q <= 1'b1;
      sel_q   <= 1'b0;
      wr_n_q  <= 1'b1;
      pipe_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      sel_n_q <= sel_n;
      sel_q   <= sel;
      wr_n_q  <= wr_n;
      pipe_q  <= pipe;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  logic hit;
  always_comb begin
    hit     = !sel_n_q && sel_q;
    op.rd   = hit && wr_n_q;
    op.wr   = hit && !wr_n_q;
    op.pipe = pipe_q;
  end

  // R9
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !op.wr && !op.rd);
endmodule

// File: rtl/dpr_xor_core.sv
module dpr_xor_core #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          a_clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_word,
  input  logic          b_clk,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_word
);
  localparam int DEPTH = 1 << AW;

  // A stored word is bank_a ^ bank_b. Each bank has one writer and one clock.
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];

  // Port A yields to a same-edge port B write of the same word: B wins.
  logic a_yield;
  assign a_yield = b_we && (b_addr == a_addr);

  always_ff @(posedge a_clk) begin
    if (a_we && !a_yield) bank_a[a_addr] <= a_din ^ bank_b[a_addr];
  end

  always_ff @(posedge b_clk) begin
    if (b_we) bank_b[b_addr] <= b_din ^ bank_a[b_addr];
  end

  // Reads see the contents before any write committing at the next edge.
  assign a_word = bank_a[a_addr] ^ bank_b[a_addr];
  assign b_word = bank_a[b_addr] ^ bank_b[b_addr];
endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage
  import dpr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dpr_op_t       op,
  input  logic [DW-1:0] word,
  input  logic          drive_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          pv;
  logic [DW-1:0] pd;

  // Second-stage register used only in pipelined mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= 1'b0;
      pd <= '0;
    end else begin
      pv <= op.rd;
      pd <= word;
    end
  end

  logic          pend_v;
  logic [DW-1:0] pend_d;
  always_comb begin
    pend_v = op.pipe ? pv : op.rd;
    pend_d = op.pipe ? pd : word;
    // drive_n is not registered: it gates the output immediately.
    rvalid = pend_v && !drive_n;
    rdata  = rvalid ? pend_d : '0;
  end

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_n |-> !rvalid);
  // R2
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.wr && !op.pipe) |-> !rvalid);
  // R1
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op.rd && !op.wr && !op.pipe) |-> !rvalid);
  // R5
  pipe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.pipe && $past(op.pipe) && !drive_n) |-> (rvalid == $past(op.rd)));
endmodule

// File: rtl/dpr_sync_ram.sv
module dpr_sync_ram
  import dpr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_sel_n,
  input  logic          a_sel,
  input  logic          a_wr_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_pipe,
  input  logic          a_drive_n,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_sel_n,
  input  logic          b_sel,
  input  logic          b_wr_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_pipe,
  input  logic          b_drive_n,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid
);
  dpr_op_t       a_op, b_op;
  logic [AW-1:0] a_addr_q, b_addr_q;
  logic [DW-1:0] a_wdata_q, b_wdata_q;
  logic [DW-1:0] a_word, b_word;

  dpr_port_ctrl #(.AW(AW), .DW(DW)) u_ctrl_a (
    .clk(a_clk), .rst_n(a_rst_n), .sel_n(a_sel_n), .sel(a_sel), .wr_n(a_wr_n),
    .addr(a_addr), .wdata(a_wdata), .pipe(a_pipe),
    .op(a_op), .addr_q(a_addr_q), .wdata_q(a_wdata_q));

  dpr_port_ctrl #(.AW(AW), .DW(DW)) u_ctrl_b (
    .clk(b_clk), .rst_n(b_rst_n), .sel_n(b_sel_n), .sel(b_sel), .wr_n(b_wr_n),
    .addr(b_addr), .wdata(b_wdata), .pipe(b_pipe),
    .op(b_op), .addr_q(b_addr_q), .wdata_q(b_wdata_q));

  dpr_xor_core #(.AW(AW), .DW(DW)) u_core (
    .a_clk(a_clk), .a_we(a_op.wr), .a_addr(a_addr_q), .a_din(a_wdata_q), .a_word(a_word),
    .b_clk(b_clk), .b_we(b_op.wr), .b_addr(b_addr_q), .b_din(b_wdata_q), .b_word(b_word));

  dpr_read_stage #(.DW(DW)) u_rd_a (
    .clk(a_clk), .rst_n(a_rst_n), .op(a_op), .word(a_word),
    .drive_n(a_drive_n), .rdata(a_rdata), .rvalid(a_rvalid));

  dpr_read_stage #(.DW(DW)) u_rd_b (
    .clk(b_clk), .rst_n(b_rst_n), .op(b_op), .word(b_word),
    .drive_n(b_drive_n), .rdata(b_rdata), .rvalid(b_rvalid));
endmodule

// File: tb/sim_dpr_sync_ram.sv
module sim_dpr_sync_ram;
  localparam int AW = 6;
  localparam int DW = 8;

  typedef struct packed {
    logic          seln;
    logic          sel;
    logic          wrn;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          pipe;
    logic          chk;
  } cmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel_n = 1'b1, a_sel = 1'b0, a_wr_n = 1'b1, a_pipe = 1'b0, a_drive_n = 1'b0;
  logic b_sel_n = 1'b1, b_sel = 1'b0, b_wr_n = 1'b1, b_pipe = 1'b0, b_drive_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  always #10 clk = ~clk;

  dpr_sync_ram #(.AW(AW), .DW(DW)) u0 (
    .a_clk(clk), .a_rst_n(rst_n), .a_sel_n(a_sel_n), .a_sel(a_sel), .a_wr_n(a_wr_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_pipe(a_pipe), .a_drive_n(a_drive_n),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(clk), .b_rst_n(rst_n), .b_sel_n(b_sel_n), .b_sel(b_sel), .b_wr_n(b_wr_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_pipe(b_pipe), .b_drive_n(b_drive_n),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid));

  int nchk = 0, nfail = 0, cyc = 0;
  logic [DW-1:0] model [1 << AW];

  // Scoreboard queues (parallel).
  int            q_due [$];
  bit            q_port[$];
  bit            q_vld [$];
  logic [DW-1:0] q_dat [$];
  string         q_req [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compare outputs with due expectations, mid-cycle.
  always @(posedge clk) begin
    #15;
    for (int i = q_due.size() - 1; i >= 0; i--) begin
      if (q_due[i] == cyc) begin
        logic          v;
        logic [DW-1:0] d;
        v = q_port[i] ? b_rvalid : a_rvalid;
        d = q_port[i] ? b_rdata : a_rdata;
        if (q_vld[i])
          check(v && d == q_dat[i], q_req[i], {7'd0, v, d}, {7'd0, 1'b1, q_dat[i]});
        else
          check(!v, q_req[i], {15'd0, v}, 16'd0);
        q_due.delete(i); q_port.delete(i); q_vld.delete(i);
        q_dat.delete(i); q_req.delete(i);
      end
    end
  end

  function automatic cmd_t rd(input int ad, input bit p);
    return '{seln: 1'b0, sel: 1'b1, wrn: 1'b1, addr: AW'(ad), data: '0, pipe: p, chk: 1'b1};
  endfunction
  function automatic cmd_t wr(input int ad, input int dt, input bit p);
    return '{seln: 1'b0, sel: 1'b1, wrn: 1'b0, addr: AW'(ad), data: DW'(dt), pipe: p, chk: 1'b1};
  endfunction
  function automatic cmd_t idle(input bit p);
    return '{seln: 1'b1, sel: 1'b0, wrn: 1'b1, addr: '0, data: '0, pipe: p, chk: 1'b0};
  endfunction
  function automatic cmd_t raw(input bit sn, input bit s, input bit w, input int ad, input int dt);
    return '{seln: sn, sel: s, wrn: w, addr: AW'(ad), data: DW'(dt), pipe: 1'b0, chk: 1'b1};
  endfunction

  task automatic expect_op(input bit port, input cmd_t c, input string req);
    bit hit;
    hit = !c.seln && c.sel;
    if (c.chk) begin
      q_due.push_back(cyc + 1 + int'(c.pipe));
      q_port.push_back(port);
      q_vld.push_back(hit && c.wrn);
      q_dat.push_back(model[c.addr]);
      q_req.push_back(req);
    end
  endtask

  // Driver: one cycle of stimulus on both ports plus the expected results.
  task automatic step(input cmd_t a, input string ra, input cmd_t b, input string rb);
    @(negedge clk);
    {a_sel_n, a_sel, a_wr_n, a_addr, a_wdata, a_pipe} = {a.seln, a.sel, a.wrn, a.addr, a.data, a.pipe};
    {b_sel_n, b_sel, b_wr_n, b_addr, b_wdata, b_pipe} = {b.seln, b.sel, b.wrn, b.addr, b.data, b.pipe};
    if (rst_n) begin
      expect_op(1'b0, a, ra);
      expect_op(1'b1, b, rb);
      if (!a.seln && a.sel && !a.wrn) model[a.addr] = a.data;
      if (!b.seln && b.sel && !b.wrn) model[b.addr] = b.data;  // B applied last: B wins
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!a_rvalid && !b_rvalid, "R9 reset", {14'd0, a_rvalid, b_rvalid}, 16'd0);
    @(negedge clk) rst_n = 1'b1;

    // R2: fill, both ports writing in the same cycles, flow-through
    for (int i = 0; i < 16; i++)
      step(wr(i, i * 7 + 3, 1'b0), "R2", wr(16 + i, 8'hA0 + i, 1'b0), "R2");
    // R3 on A, R5/R6 on B (pipelined while A is flow-through)
    for (int i = 0; i < 16; i++)
      step(rd(16 + i, 1'b0), "R3", rd(i, 1'b1), "R5_R6");
    step(idle(1'b0), "", idle(1'b1), "");
    // R7: same word, same cycle; then both read it (R10)
    step(wr(7, 8'hAA, 1'b0), "R7", wr(7, 8'h55, 1'b0), "R7");
    step(rd(7, 1'b0), "R7", rd(7, 1'b0), "R10");
    // R8: B reads word 8 while A writes it
    step(wr(8, 8'hC3, 1'b0), "R2", rd(8, 1'b0), "R8");
    step(rd(8, 1'b0), "R2", rd(8, 1'b0), "R8");
    // R2: back-to-back write then read on one port
    step(wr(9, 8'h5A, 1'b0), "R2", idle(1'b0), "");
    step(rd(9, 1'b0), "R2", idle(1'b0), "");
    // R1: every non-selecting pair
    step(raw(1, 1, 0, 3, 8'hFF), "R1", raw(0, 0, 1, 4, 0), "R1");
    step(raw(1, 0, 1, 3, 0), "R1", raw(1, 0, 0, 4, 8'hEE), "R1");
    step(raw(0, 0, 0, 3, 8'h77), "R1", raw(1, 1, 1, 4, 0), "R1");
    step(rd(3, 1'b0), "R1", rd(4, 1'b0), "R1");
    // R6: A pipelined, B flow-through at once
    step(rd(20, 1'b1), "R6", rd(21, 1'b0), "R6");
    step(rd(5, 1'b1), "R6", rd(6, 1'b0), "R6");
    step(idle(1'b1), "", idle(1'b0), "");
    step(idle(1'b0), "", idle(1'b0), "");
    repeat (3) step(idle(1'b0), "", idle(1'b0), "");

    // R4: drive control acts without a clock edge
    step(rd(10, 1'b0), "R3", idle(1'b0), "");
    @(posedge clk); #5;
    check(a_rvalid && a_rdata == model[10], "R3", {7'd0, a_rvalid, a_rdata}, {7'd0, 1'b1, model[10]});
    a_drive_n = 1'b1; #1;
    check(!a_rvalid, "R4 off", {15'd0, a_rvalid}, 16'd0);
    a_drive_n = 1'b0; #1;
    check(a_rvalid && a_rdata == model[10], "R4 on", {7'd0, a_rvalid, a_rdata}, {7'd0, 1'b1, model[10]});
    step(idle(1'b0), "", idle(1'b0), "");

    // R9: writes during reset are dropped
    @(negedge clk) rst_n = 1'b0;
    step(wr(5, 8'h99, 1'b0), "", wr(6, 8'h66, 1'b0), "");
    step(wr(5, 8'h99, 1'b0), "", wr(6, 8'h66, 1'b0), "");
    #5 check(!a_rvalid && !b_rvalid, "R9 in reset", {14'd0, a_rvalid, b_rvalid}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    {a_sel_n, a_sel, b_sel_n, b_sel} = 4'b1010;
    step(rd(5, 1'b0), "R9", rd(6, 1'b1), "R9");
    repeat (4) step(idle(1'b1), "", idle(1'b1), "");

    check(q_due.size() == 0, "scoreboard drained", 16'(q_due.size()), 16'd0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 16'(cyc), 16'd0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule